// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer of 1024 words of 18 bits. The producer and the consumer each have their own clock. The write enable, read enable, reset and all status flags are active low. A producer writes words on the write clock, and a consumer takes them out on the read clock. The buffer drives four kinds of status: full/empty (or ready) flags, an almost-empty flag, an almost-full flag and a half-full flag. The almost-empty and almost-full thresholds come from two 12-bit offset registers. These registers have no separate port. Software writes them over the normal data input while the load strobe is low, and reads them back on the normal data output.

A mode input chooses between two modes, and the block takes it only while reset is held. In standard mode, each read request copies the oldest word into the output register. In fall-through mode, the oldest word moves to the output on its own. The two flag pins then report input-ready and output-ready. Pointers cross between the clock domains as Gray codes. Each domain computes the flags it owns. The level used by every flag is the number of words in storage that have not yet moved to the output stage.

Top module: `dual_clock_fifo`

## Requirements
- R1: While `rst_n` is low for at least three edges of each clock, both pointers return to zero. Both offsets become 127, `ae_n` is low, `af_n` is high and `hf_n` is high. `wr_flag_n` is high in standard mode and low in fall-through mode. `rd_flag_n` is low in standard mode and high in fall-through mode.
- R2: On a rising `wclk` edge with `wen_n` low and `ld_n` high, `din` is stored, but only if the buffer is not full. A write attempted while full is dropped: the stored words and their order do not change.
- R3: In standard mode, a rising `rclk` edge with `ren_n` low and `ld_n` high loads the oldest stored word into `q`, if any word is stored. With `ren_n` high, `q` keeps its value. A read while empty leaves `q` unchanged.
- R4: A rising `wclk` edge with `ld_n` low and `wen_n` low copies `din[11:0]` into an offset register and stores no data word. The first load after reset goes to the empty offset, the next to the full offset, and they keep alternating.
- R5: In standard mode, a rising `rclk` edge with `ld_n` low and `ren_n` low puts an offset on `q`: the empty offset first, then the full offset, alternating from reset. Bits 17:12 are zero and no word is removed.
- R6: `ae_n` is low exactly when the level is at most the empty offset.
- R7: `af_n` is low exactly when the level plus the full offset is at least 1024.
- R8: `hf_n` is low exactly when the level is above 512.
- R9: In standard mode, `wr_flag_n` is low exactly when 1024 words are stored.
- R10: In fall-through mode, the oldest stored word appears on `q` with no read request, and `rd_flag_n` goes low while `q` holds a valid word. A read with `ld_n` high consumes that word, and the next stored word follows. `wr_flag_n` is low while space remains.
- R11: The mode is sampled only while `rst_n` is low (`mode_fwft` = 1 selects fall-through). Changing `mode_fwft` after reset has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, synchronous to both clocks |
| mode_fwft | input | 1 | Mode select sampled during reset: 1 fall-through, 0 standard |
| wen_n | input | 1 | Active-low write enable |
| ren_n | input | 1 | Active-low read enable |
| ld_n | input | 1 | Active-low offset load / readback strobe |
| din | input | 18 | Write data; bits 11:0 carry offsets during loads |
| q | output | 18 | Output register |
| wr_flag_n | output | 1 | Full (standard) or input-ready (fall-through), active low |
| rd_flag_n | output | 1 | Empty (standard) or output-ready (fall-through), active low |
| ae_n | output | 1 | Almost-empty, active low |
| af_n | output | 1 | Almost-full, active low |
| hf_n | output | 1 | Half-full, active low |

## Verification
Any error in a pointer or in the Gray conversion shows up at the ports as a word out of order. It can also show up as a level flag that switches at the wrong count, once the pointer has passed through the synchronizer stages, a few clock edges later. Errors in the offset toggle or in the load path appear on the very next readback, as the wrong offset value. Almost-empty and almost-full then switch at the wrong fill level. A mode latch that follows the live input would show fall-through data on `q` with no read request, even though reset had selected standard mode.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FWFT = 1'b1
   } dcf_mode_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int W      = 11,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) st[0] <= '0;
            else        st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) st[i] <= '0;
            else        st[i] <= st[i-1];
         end
      end
   end

   assign q = st[STAGES-1];

   initial begin
      assert (STAGES >= 2) else $error("dcf_sync needs at least two stages");
   end
endmodule

// File: rtl/dcf_wr.sv
module dcf_wr
   import dcf_pkg::*;
#(
   parameter int AW          = 10,
   parameter int OW          = 12,
   parameter int OFS_RST     = 127,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wclk,
   input  logic          rst_n,
   input  logic          mode_fwft,
   input  logic          wen_n,
   input  logic          ld_n,
   input  logic [OW-1:0] ofs_in,
   input  logic [AW:0]   rgray,
   output logic [AW:0]   wgray,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [OW-1:0] eoff,
   output logic [OW-1:0] foff,
   output logic          wr_flag_n,
   output logic          af_n,
   output logic          hf_n
);
   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;
   localparam int HALF  = DEPTH / 2;

   dcf_mode_e   mode_w;
   logic [PW-1:0] wbin, rgray_s, rbin_s, level, wbin_nx;
   logic        full, push, load, ltog;

   dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
      .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
   );

   always_comb begin
      for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
   end

   assign level   = wbin - rbin_s;
   assign full    = (level == PW'(DEPTH));
   assign push    = !wen_n && ld_n && !full;
   assign load    = !wen_n && !ld_n;
   assign wbin_nx = wbin + PW'(1);

   always_ff @(posedge wclk) begin
      if (!rst_n) begin
         wbin   <= '0;
         wgray  <= '0;
         ltog   <= 1'b0;
         eoff   <= OW'(OFS_RST);
         foff   <= OW'(OFS_RST);
         mode_w <= dcf_mode_e'(mode_fwft);   // R11: taken only in reset
      end else if (load) begin
         ltog <= ~ltog;
         if (ltog) foff <= ofs_in;
         else      eoff <= ofs_in;
      end else if (push) begin
         wbin  <= wbin_nx;
         wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   assign we        = push;
   assign waddr     = wbin[AW-1:0];
   assign wr_flag_n = (mode_w == MODE_FWFT) ? full : !full;
   assign af_n      = !((int'(level) + int'(foff)) >= DEPTH);
   assign hf_n      = !(int'(level) > HALF);

   AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
      int'(level) <= DEPTH);                                        // R2
   AST_FULL_DROPS: assert property (@(posedge wclk) disable iff (!rst_n)
      (!wen_n && ld_n && full) |=> $stable(wbin));                  // R2
   AST_LOAD_NO_PUSH: assert property (@(posedge wclk) disable iff (!rst_n)
      (!wen_n && !ld_n) |=> $stable(wbin));                         // R4
endmodule

// File: rtl/dcf_rd.sv
module dcf_rd
   import dcf_pkg::*;
#(
   parameter int DW          = 18,
   parameter int AW          = 10,
   parameter int OW          = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          mode_fwft,
   input  logic          ren_n,
   input  logic          ld_n,
   input  logic [AW:0]   wgray,
   input  logic [DW-1:0] rd_word,
   input  logic [OW-1:0] eoff,
   input  logic [OW-1:0] foff,
   output logic [AW:0]   rgray,
   output logic [AW-1:0] raddr,
   output logic [DW-1:0] q,
   output logic          rd_flag_n,
   output logic          ae_n
);
   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   dcf_mode_e   mode_r;
   logic [PW-1:0] rbin, wgray_s, wbin_s, level, rbin_nx;
   logic        empty, ovalid, rtog, fwft, pop, consume, rdback;

   dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
      .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
   );

   always_comb begin
      for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
   end

   assign level   = wbin_s - rbin;
   assign empty   = (level == '0);
   assign fwft    = (mode_r == MODE_FWFT);
   assign consume = !ren_n && ld_n;
   assign rdback  = !fwft && !ren_n && !ld_n;
   assign pop     = !empty && (fwft ? (!ovalid || consume) : consume);
   assign rbin_nx = rbin + PW'(1);

   always_ff @(posedge rclk) begin
      if (!rst_n) begin
         rbin   <= '0;
         rgray  <= '0;
         q      <= '0;
         ovalid <= 1'b0;
         rtog   <= 1'b0;
         mode_r <= dcf_mode_e'(mode_fwft);   // R11: taken only in reset
      end else if (pop) begin
         rbin   <= rbin_nx;
         rgray  <= rbin_nx ^ (rbin_nx >> 1);
         q      <= rd_word;
         ovalid <= 1'b1;
      end else if (fwft && consume) begin
         ovalid <= 1'b0;
      end else if (rdback) begin
         rtog <= ~rtog;
         q    <= rtog ? DW'(foff) : DW'(eoff);
      end
   end

   assign raddr     = rbin[AW-1:0];
   assign rd_flag_n = fwft ? !ovalid : !empty;
   assign ae_n      = !(int'(level) <= int'(eoff));

   AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
      int'(level) <= DEPTH);                                        // R3
   AST_HOLD_OUT: assert property (@(posedge rclk) disable iff (!rst_n)
      (!fwft && ren_n) |=> $stable(q));                             // R3
   AST_RDBACK_NO_POP: assert property (@(posedge rclk) disable iff (!rst_n)
      (!fwft && !ren_n && !ld_n) |=> $stable(rbin));                // R5
   AST_FWFT_SHOWS: assert property (@(posedge rclk) disable iff (!rst_n)
      (fwft && !empty && ren_n) |=> !rd_flag_n);                    // R10
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
   parameter int DW          = 18,
   parameter int AW          = 10,
   parameter int OW          = 12,
   parameter int OFS_RST     = 127,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          mode_fwft,
   input  logic          wen_n,
   input  logic          ren_n,
   input  logic          ld_n,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] q,
   output logic          wr_flag_n,
   output logic          rd_flag_n,
   output logic          ae_n,
   output logic          af_n,
   output logic          hf_n
);
   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] ram [DEPTH];
   logic          we;
   logic [AW-1:0] waddr, raddr;
   logic [PW-1:0] wgray, rgray;
   logic [OW-1:0] eoff, foff;

   always_ff @(posedge wclk) begin
      if (we) ram[waddr] <= din;
   end

   dcf_wr #(.AW(AW), .OW(OW), .OFS_RST(OFS_RST), .SYNC_STAGES(SYNC_STAGES)) u_wr (
      .wclk(wclk), .rst_n(rst_n), .mode_fwft(mode_fwft), .wen_n(wen_n),
      .ld_n(ld_n), .ofs_in(din[OW-1:0]), .rgray(rgray), .wgray(wgray),
      .we(we), .waddr(waddr), .eoff(eoff), .foff(foff),
      .wr_flag_n(wr_flag_n), .af_n(af_n), .hf_n(hf_n)
   );

   dcf_rd #(.DW(DW), .AW(AW), .OW(OW), .SYNC_STAGES(SYNC_STAGES)) u_rd (
      .rclk(rclk), .rst_n(rst_n), .mode_fwft(mode_fwft), .ren_n(ren_n),
      .ld_n(ld_n), .wgray(wgray), .rd_word(ram[raddr]), .eoff(eoff),
      .foff(foff), .rgray(rgray), .raddr(raddr), .q(q),
      .rd_flag_n(rd_flag_n), .ae_n(ae_n)
   );

   initial begin
      assert (DW >= OW) else $error("data width must hold an offset");
      assert (AW >= 2 && AW <= 16) else $error("address width out of range");
      assert (OFS_RST < (1 << OW)) else $error("reset offset too wide");
   end
endmodule

// File: tb/dual_clock_fifo_tb.sv
module dual_clock_fifo_tb;
   localparam int DW = 18;
   localparam int DEPTH = 1024;

   logic wclk = 1'b0, rclk = 1'b0;
   logic rst_n = 1'b0, mode_fwft = 1'b0;
   logic wen_n = 1'b1, ren_n = 1'b1, ld_n = 1'b1;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] q;
   logic wr_flag_n, rd_flag_n, ae_n, af_n, hf_n;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [DW-1:0] model [$];
   int eofs = 127, fofs = 127;

   always #5 wclk = ~wclk;
   always #7 rclk = ~rclk;

   dual_clock_fifo u_dut (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .mode_fwft(mode_fwft),
      .wen_n(wen_n), .ren_n(ren_n), .ld_n(ld_n), .din(din), .q(q),
      .wr_flag_n(wr_flag_n), .rd_flag_n(rd_flag_n), .ae_n(ae_n),
      .af_n(af_n), .hf_n(hf_n)
   );

   function automatic logic exp_ae(int lvl, int eo);
      return (lvl <= eo) ? 1'b0 : 1'b1;
   endfunction
   function automatic logic exp_af(int lvl, int fo);
      return (lvl + fo >= DEPTH) ? 1'b0 : 1'b1;
   endfunction
   function automatic logic exp_hf(int lvl);
      return (lvl > DEPTH / 2) ? 1'b0 : 1'b1;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (8) @(negedge wclk);
      repeat (8) @(negedge rclk);
   endtask

   task automatic do_reset(logic m);
      rst_n = 1'b0; mode_fwft = m;
      repeat (5) @(negedge wclk);
      repeat (5) @(negedge rclk);
      rst_n = 1'b1;
      model.delete(); eofs = 127; fofs = 127;
      settle();
   endtask

   task automatic push(logic [DW-1:0] w);
      @(negedge wclk); wen_n = 1'b0; ld_n = 1'b1; din = w;
      @(negedge wclk); wen_n = 1'b1;
      if (model.size() < DEPTH) model.push_back(w);
   endtask

   task automatic wr_load(int v);
      @(negedge wclk); wen_n = 1'b0; ld_n = 1'b0; din = DW'(v);
      @(negedge wclk); wen_n = 1'b1; ld_n = 1'b1;
   endtask

   task automatic rd_pulse(logic ld);
      @(negedge rclk); ren_n = 1'b0; ld_n = ld;
      @(negedge rclk); ren_n = 1'b1; ld_n = 1'b1;
   endtask

   task automatic pop_check(string req);
      logic [DW-1:0] e;
      e = model.pop_front();
      rd_pulse(1'b1);
      chk(req, int'(q), int'(e));
   endtask

   initial begin
      repeat (200000) @(posedge wclk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] hold;
      process::self().srandom(32'd1234);
      // ---------- standard mode ----------
      do_reset(1'b0);
      chk("R1 wr_flag_n", int'(wr_flag_n), 1);
      chk("R1 rd_flag_n", int'(rd_flag_n), 0);
      chk("R1 ae_n", int'(ae_n), 0);
      chk("R1 af_n", int'(af_n), 1);
      chk("R1 hf_n", int'(hf_n), 1);
      rd_pulse(1'b0); chk("R1 R5 empty offset default", int'(q), 127);
      rd_pulse(1'b0); chk("R1 R5 full offset default", int'(q), 127);

      wr_load(5);  eofs = 5;
      wr_load(10); fofs = 10;
      settle();
      chk("R4 load stores no word", int'(rd_flag_n), 0);
      rd_pulse(1'b0); chk("R4 R5 empty offset", int'(q), 5);
      rd_pulse(1'b0); chk("R4 R5 full offset", int'(q), 10);

      // readback does not pop
      push(18'h1A5A5); push(18'h2C3C3); settle();
      rd_pulse(1'b0); chk("R5 readback value", int'(q), 5);
      pop_check("R5 readback kept word");
      pop_check("R3 second word");

      // random traffic
      for (int it = 0; it < 8; it++) begin
         int nw, nr;
         nw = 2 + int'($urandom % 7);
         for (int k = 0; k < nw; k++) push(DW'($urandom));
         settle();
         chk("R6 ae_n after writes", int'(ae_n), int'(exp_ae(model.size(), eofs)));
         chk("R8 hf_n small level", int'(hf_n), int'(exp_hf(model.size())));
         nr = int'($urandom % (model.size() + 1));
         for (int k = 0; k < nr; k++) pop_check("R3 random order");
         settle();
         chk("R6 ae_n after reads", int'(ae_n), int'(exp_ae(model.size(), eofs)));
      end
      while (model.size() > 0) pop_check("R3 drain");
      settle();

      // hold and read while empty
      push(18'h0BEEF); settle(); pop_check("R3 single");
      hold = q;
      repeat (6) @(negedge rclk);
      chk("R3 hold with ren_n high", int'(q), int'(hold));
      rd_pulse(1'b1); settle();
      chk("R3 read while empty", int'(q), int'(hold));
      chk("R3 empty flag", int'(rd_flag_n), 0);

      // fill to boundaries
      for (int k = 0; k < 512; k++) push(DW'($urandom));
      settle();
      chk("R8 hf_n at 512", int'(hf_n), 1);
      push(DW'($urandom)); settle();
      chk("R8 hf_n at 513", int'(hf_n), 0);
      while (model.size() < 1013) push(DW'($urandom));
      settle();
      chk("R7 af_n at 1013", int'(af_n), int'(exp_af(1013, fofs)));
      chk("R6 ae_n high when deep", int'(ae_n), 1);
      push(DW'($urandom)); settle();
      chk("R7 af_n at 1014", int'(af_n), int'(exp_af(1014, fofs)));
      while (model.size() < 1023) push(DW'($urandom));
      settle();
      chk("R9 not full at 1023", int'(wr_flag_n), 1);
      push(DW'($urandom)); settle();
      chk("R9 full at 1024", int'(wr_flag_n), 0);
      push(18'h3ABCD); settle();
      chk("R2 write while full keeps full", int'(wr_flag_n), 0);
      while (model.size() > 0) pop_check("R2 R3 drain after full");
      settle();
      chk("R2 dropped word absent", int'(rd_flag_n), 0);

      // ---------- fall-through mode ----------
      do_reset(1'b1);
      chk("R1 R10 ready flag fwft", int'(wr_flag_n), 0);
      chk("R1 R10 out not ready", int'(rd_flag_n), 1);
      push(18'h11111); settle();
      chk("R10 first word falls through", int'(q), 18'h11111);
      chk("R10 output ready", int'(rd_flag_n), 0);
      push(18'h22222); settle();
      chk("R10 head held", int'(q), 18'h11111);
      rd_pulse(1'b1); settle();
      chk("R10 next word", int'(q), 18'h22222);
      rd_pulse(1'b1); settle();
      chk("R10 drained", int'(rd_flag_n), 1);
      mode_fwft = 1'b0;
      push(18'h33333); settle();
      chk("R11 mode ignored after reset", int'(q), 18'h33333);
      chk("R11 still output ready", int'(rd_flag_n), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule